// File: doc/BRIEF.md
# Prescaled Seconds Counter with Alarm

This block keeps time in a slow, free-running clock domain and presents it to software through a small 16-bit register window in the bus clock domain. A reloadable prescaler divides the slow clock down to a tick. Each tick advances a 32-bit counter and raises a tick flag. An alarm flag rises when the counter steps onto a programmed compare value. Either flag can drive the interrupt output through its own enable.

Software changes the prescaler reload, the counter or the compare value by first setting a configuration-mode bit and writing the halves it wants. It then clears the bit. Clearing it starts a toggle handshake that carries every changed field into the slow domain in one step. A done bit stays low while the handshake runs. A synchronised bit shows when the counter snapshot held on the bus side is valid. The counter is read low half first. That read also freezes the high half, so the 32-bit value reads back consistently. The bus clock is expected to run at least four times faster than the slow clock.

Top module: `sec_counter`

## Requirements
- R1: The prescaler reload value R is 20 bits: bits 19:16 sit in bits 3:0 of address 1 and bits 15:0 at address 2. After R is loaded, the counter advances once every R+1 slow-clock cycles. R = 0 is not a supported setting.
- R2: Each tick adds one to the 32-bit counter and carries from the low half into the high half. A bus read of address 4 returns counter bits 15:0 and latches bits 31:16, which a later read of address 3 returns.
- R3: The counter wraps from 0xFFFFFFFF to 0x00000000.
- R4: Writes to addresses 1 to 6 change nothing unless control bit 2 (configuration mode) is set and control bit 3 (done) reads 1. The control register sits at address 0. Addresses 5 and 6 hold the alarm high and low halves, and reads of addresses 1, 2, 5 and 6 return the stored values.
- R5: A control write that clears bit 2, after at least one field has been written in configuration mode, starts a transfer. Bit 3 then reads 0 until the slow domain has taken every written field, and 1 afterwards. The loaded counter value is then readable.
- R6: Control bit 4 (synchronised) is 0 after reset and for the whole of a transfer. It becomes 1 when a counter snapshot from the slow domain has been taken.
- R7: Control bit 0 (tick flag) is set each time the counter increments.
- R8: Control bit 1 (alarm flag) is set when the counter steps onto the value held in the alarm register. It is not set on the step before.
- R9: Writing 0 to control bit 0 or bit 1 clears that flag. Writing 1 leaves it unchanged.
- R10: The irq output is high when the tick flag is set with tick enable (control bit 5) set, or the alarm flag is set with alarm enable (control bit 6) set. It is low otherwise.
- R11: After reset the control register reads 0x0008 (done set, all else clear) and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst_n | input | 1 | Bus-side active-low reset |
| slow_clk | input | 1 | Slow counting clock |
| slow_rst_n | input | 1 | Slow-domain active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe for one bus cycle |
| bus_re | input | 1 | Read strobe for one bus cycle, used to latch the counter high half |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | 1 | Interrupt request |

## Verification
The counter is loaded with values chosen to expose different faults. A value just below a 16-bit boundary shows whether the carry reaches the high half. A value just below all ones shows the wrap. A value two steps before the alarm compare tells a match on the stored value apart from a match one step early. The tick interval is timed with two different reload values, which separates a division by R+1 from a division by R or by a fixed amount. The flag tests write 1 to one flag and 0 to the other in the same control write, which separates clear-on-zero from clear-on-any-write.

// File: rtl/sec_counter_pkg.sv
package sec_counter_pkg;

   typedef enum logic [2:0] {
      A_CTRL   = 3'd0,
      A_RLD_HI = 3'd1,
      A_RLD_LO = 3'd2,
      A_CNT_HI = 3'd3,
      A_CNT_LO = 3'd4,
      A_ALM_HI = 3'd5,
      A_ALM_LO = 3'd6
   } sec_addr_e;

   localparam int unsigned B_TICKF = 0;
   localparam int unsigned B_ALMF  = 1;
   localparam int unsigned B_CFG   = 2;
   localparam int unsigned B_DONE  = 3;
   localparam int unsigned B_SYNC  = 4;
   localparam int unsigned B_TIE   = 5;
   localparam int unsigned B_AIE   = 6;

   localparam int unsigned N_FIELDS = 3;
   localparam int unsigned F_RLD    = 0;
   localparam int unsigned F_CNT    = 1;
   localparam int unsigned F_ALM    = 2;

endpackage

// File: rtl/sec_toggle_sync.sv
module sec_toggle_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl_in,
   output logic pulse_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sec_toggle_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[0] <= 1'b0;
      else        pipe_q[0] <= tgl_in;
   end

   for (genvar g = 1; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q[g] <= 1'b0;
         else        pipe_q[g] <= pipe_q[g-1];
      end
   end

   assign pulse_o = pipe_q[STAGES] ^ pipe_q[STAGES-1];

endmodule

// File: rtl/sec_bus_regs.sv
module sec_bus_regs
   import sec_counter_pkg::*;
#(
   parameter int unsigned HALF_W       = 16,
   parameter int unsigned PSC_W        = 20,
   parameter int unsigned CNT_W        = 32,
   parameter int unsigned RESET_RELOAD = 32767
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          bus_addr,
   input  logic                bus_we,
   input  logic                bus_re,
   input  logic [HALF_W-1:0]   bus_wdata,
   output logic [HALF_W-1:0]   bus_rdata,
   output logic                irq,
   input  logic                ack_pulse,
   input  logic                tick_pulse,
   input  logic                alm_pulse,
   input  logic [CNT_W-1:0]    cnt_live,
   output logic                req_tgl,
   output logic [N_FIELDS-1:0] dirty,
   output logic [PSC_W-1:0]    sh_reload,
   output logic [CNT_W-1:0]    sh_cnt,
   output logic [CNT_W-1:0]    sh_alarm,
   output logic                cfg_mode,
   output logic                done,
   output logic                synced,
   output logic                tick_flag,
   output logic                alm_flag,
   output logic                tick_ie,
   output logic                alm_ie
);

   localparam int unsigned PSC_HI_W = PSC_W - HALF_W;

   sec_addr_e           addr_e;
   logic                wr_ctrl;
   logic                data_ok;
   logic                start_xfer;
   logic [HALF_W-1:0]   snap_hi_hold;
   logic [CNT_W-1:0]    snap_q;

   always_comb addr_e = sec_addr_e'(bus_addr);

   assign wr_ctrl    = bus_we && (addr_e == A_CTRL);
   assign data_ok    = bus_we && cfg_mode && done;
   assign start_xfer = wr_ctrl && cfg_mode && !bus_wdata[B_CFG] && done && (|dirty);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_mode     <= 1'b0;
         tick_ie      <= 1'b0;
         alm_ie       <= 1'b0;
         tick_flag    <= 1'b0;
         alm_flag     <= 1'b0;
         done         <= 1'b1;
         synced       <= 1'b0;
         req_tgl      <= 1'b0;
         dirty        <= '0;
         sh_reload    <= PSC_W'(RESET_RELOAD);
         sh_cnt       <= '0;
         sh_alarm     <= '1;
         snap_q       <= '0;
         snap_hi_hold <= '0;
      end else begin
         if (wr_ctrl) begin
            cfg_mode <= bus_wdata[B_CFG];
            tick_ie  <= bus_wdata[B_TIE];
            alm_ie   <= bus_wdata[B_AIE];
         end
         // a new event wins over a simultaneous clear
         tick_flag <= tick_pulse | (tick_flag & ~(wr_ctrl & ~bus_wdata[B_TICKF]));
         alm_flag  <= alm_pulse  | (alm_flag  & ~(wr_ctrl & ~bus_wdata[B_ALMF]));

         if (start_xfer) begin
            req_tgl <= ~req_tgl;
            done    <= 1'b0;
            synced  <= 1'b0;
         end else if (ack_pulse) begin
            done    <= 1'b1;
            synced  <= 1'b1;
            dirty   <= '0;
         end else if (tick_pulse && done) begin
            synced  <= 1'b1;
         end

         if (ack_pulse || tick_pulse) snap_q <= cnt_live;

         if (data_ok) begin
            unique case (addr_e)
               A_RLD_HI: begin
                  sh_reload[PSC_W-1:HALF_W] <= bus_wdata[PSC_HI_W-1:0];
                  dirty[F_RLD] <= 1'b1;
               end
               A_RLD_LO: begin
                  sh_reload[HALF_W-1:0] <= bus_wdata;
                  dirty[F_RLD] <= 1'b1;
               end
               A_CNT_HI: begin
                  sh_cnt[CNT_W-1:HALF_W] <= bus_wdata;
                  dirty[F_CNT] <= 1'b1;
               end
               A_CNT_LO: begin
                  sh_cnt[HALF_W-1:0] <= bus_wdata;
                  dirty[F_CNT] <= 1'b1;
               end
               A_ALM_HI: begin
                  sh_alarm[CNT_W-1:HALF_W] <= bus_wdata;
                  dirty[F_ALM] <= 1'b1;
               end
               A_ALM_LO: begin
                  sh_alarm[HALF_W-1:0] <= bus_wdata;
                  dirty[F_ALM] <= 1'b1;
               end
               default: ;
            endcase
         end

         if (bus_re && (addr_e == A_CNT_LO)) snap_hi_hold <= snap_q[CNT_W-1:HALF_W];
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (addr_e)
         A_CTRL: begin
            bus_rdata[B_TICKF] = tick_flag;
            bus_rdata[B_ALMF]  = alm_flag;
            bus_rdata[B_CFG]   = cfg_mode;
            bus_rdata[B_DONE]  = done;
            bus_rdata[B_SYNC]  = synced;
            bus_rdata[B_TIE]   = tick_ie;
            bus_rdata[B_AIE]   = alm_ie;
         end
         A_RLD_HI: bus_rdata[PSC_HI_W-1:0] = sh_reload[PSC_W-1:HALF_W];
         A_RLD_LO: bus_rdata = sh_reload[HALF_W-1:0];
         A_CNT_HI: bus_rdata = snap_hi_hold;
         A_CNT_LO: bus_rdata = snap_q[HALF_W-1:0];
         A_ALM_HI: bus_rdata = sh_alarm[CNT_W-1:HALF_W];
         A_ALM_LO: bus_rdata = sh_alarm[HALF_W-1:0];
         default:  bus_rdata = '0;
      endcase
   end

   assign irq = (tick_flag & tick_ie) | (alm_flag & alm_ie);

endmodule

// File: rtl/sec_count_core.sv
module sec_count_core
   import sec_counter_pkg::*;
#(
   parameter int unsigned PSC_W        = 20,
   parameter int unsigned CNT_W        = 32,
   parameter int unsigned RESET_RELOAD = 32767
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_pulse,
   input  logic [N_FIELDS-1:0] dirty,
   input  logic [PSC_W-1:0]    sh_reload,
   input  logic [CNT_W-1:0]    sh_cnt,
   input  logic [CNT_W-1:0]    sh_alarm,
   output logic [CNT_W-1:0]    cnt_o,
   output logic                ack_tgl,
   output logic                tick_tgl,
   output logic                alm_tgl,
   output logic                tick_o,
   output logic                ld_cnt_o
);

   logic [PSC_W-1:0] reload_q;
   logic [PSC_W-1:0] psc_q;
   logic [CNT_W-1:0] alm_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             ld_rld;
   logic             ld_cnt;
   logic             ld_alm;
   logic             step;

   assign ld_rld  = load_pulse && dirty[F_RLD];
   assign ld_cnt  = load_pulse && dirty[F_CNT];
   assign ld_alm  = load_pulse && dirty[F_ALM];
   assign tick_o  = (psc_q == '0) && !ld_rld;
   assign step    = tick_o && !ld_cnt;
   assign cnt_inc = cnt_o + CNT_W'(1);
   assign ld_cnt_o = ld_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= PSC_W'(RESET_RELOAD);
         psc_q    <= PSC_W'(RESET_RELOAD);
         alm_q    <= '1;
         cnt_o    <= '0;
         ack_tgl  <= 1'b0;
         tick_tgl <= 1'b0;
         alm_tgl  <= 1'b0;
      end else begin
         if (ld_rld) begin
            reload_q <= sh_reload;
            psc_q    <= sh_reload;
         end else if (psc_q == '0) begin
            psc_q    <= reload_q;
         end else begin
            psc_q    <= psc_q - PSC_W'(1);
         end

         if (ld_cnt)    cnt_o <= sh_cnt;
         else if (step) cnt_o <= cnt_inc;

         if (ld_alm) alm_q <= sh_alarm;

         if (step) begin
            tick_tgl <= ~tick_tgl;
            if (cnt_inc == alm_q) alm_tgl <= ~alm_tgl;
         end

         if (load_pulse) ack_tgl <= ~ack_tgl;
      end
   end

endmodule

// File: rtl/sec_counter.sv
module sec_counter
   import sec_counter_pkg::*;
#(
   parameter int unsigned HALF_W       = 16,
   parameter int unsigned PSC_W        = 20,
   parameter int unsigned CNT_W        = 32,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned RESET_RELOAD = 32767
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              slow_clk,
   input  logic              slow_rst_n,
   input  logic [2:0]        bus_addr,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [HALF_W-1:0] bus_wdata,
   output logic [HALF_W-1:0] bus_rdata,
   output logic              irq
);

   if (PSC_W <= HALF_W || PSC_W > 2 * HALF_W) begin : g_bad_psc
      $error("sec_counter: PSC_W must lie between HALF_W+1 and 2*HALF_W");
   end
   if (CNT_W != 2 * HALF_W) begin : g_bad_cnt
      $error("sec_counter: CNT_W must be two halves wide");
   end
   if (RESET_RELOAD < 1 || RESET_RELOAD >= (64'd1 << PSC_W)) begin : g_bad_rld
      $error("sec_counter: RESET_RELOAD out of range");
   end

   logic                req_tgl;
   logic                req_pulse;
   logic                ack_tgl;
   logic                ack_pulse;
   logic                tick_tgl;
   logic                tick_set;
   logic                alm_tgl;
   logic                alm_set;
   logic [N_FIELDS-1:0] dirty;
   logic [PSC_W-1:0]    sh_reload;
   logic [CNT_W-1:0]    sh_cnt;
   logic [CNT_W-1:0]    sh_alarm;
   logic [CNT_W-1:0]    cnt;
   logic                cfg_mode;
   logic                done;
   logic                synced;
   logic                tick_flag;
   logic                alm_flag;
   logic                tick_ie;
   logic                alm_ie;
   logic                core_tick;
   logic                core_ld_cnt;

   sec_bus_regs #(
      .HALF_W(HALF_W), .PSC_W(PSC_W), .CNT_W(CNT_W), .RESET_RELOAD(RESET_RELOAD)
   ) u_regs (
      .clk(bus_clk), .rst_n(bus_rst_n),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .ack_pulse(ack_pulse), .tick_pulse(tick_set), .alm_pulse(alm_set),
      .cnt_live(cnt), .req_tgl(req_tgl), .dirty(dirty),
      .sh_reload(sh_reload), .sh_cnt(sh_cnt), .sh_alarm(sh_alarm),
      .cfg_mode(cfg_mode), .done(done), .synced(synced),
      .tick_flag(tick_flag), .alm_flag(alm_flag),
      .tick_ie(tick_ie), .alm_ie(alm_ie)
   );

   sec_toggle_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(slow_clk), .rst_n(slow_rst_n), .tgl_in(req_tgl), .pulse_o(req_pulse)
   );
   sec_toggle_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(bus_clk), .rst_n(bus_rst_n), .tgl_in(ack_tgl), .pulse_o(ack_pulse)
   );
   sec_toggle_sync #(.STAGES(SYNC_STAGES)) u_tick_sync (
      .clk(bus_clk), .rst_n(bus_rst_n), .tgl_in(tick_tgl), .pulse_o(tick_set)
   );
   sec_toggle_sync #(.STAGES(SYNC_STAGES)) u_alm_sync (
      .clk(bus_clk), .rst_n(bus_rst_n), .tgl_in(alm_tgl), .pulse_o(alm_set)
   );

   sec_count_core #(
      .PSC_W(PSC_W), .CNT_W(CNT_W), .RESET_RELOAD(RESET_RELOAD)
   ) u_core (
      .clk(slow_clk), .rst_n(slow_rst_n), .load_pulse(req_pulse),
      .dirty(dirty), .sh_reload(sh_reload), .sh_cnt(sh_cnt), .sh_alarm(sh_alarm),
      .cnt_o(cnt), .ack_tgl(ack_tgl), .tick_tgl(tick_tgl), .alm_tgl(alm_tgl),
      .tick_o(core_tick), .ld_cnt_o(core_ld_cnt)
   );

endmodule

// File: rtl/sec_counter_chk.sv
module sec_counter_chk #(
   parameter int unsigned HALF_W = 16,
   parameter int unsigned CNT_W  = 32
) (
   input logic              bus_clk,
   input logic              bus_rst_n,
   input logic              slow_clk,
   input logic              slow_rst_n,
   input logic [2:0]        bus_addr,
   input logic              bus_we,
   input logic [HALF_W-1:0] bus_wdata,
   input logic              irq,
   input logic              cfg_mode,
   input logic              done,
   input logic              synced,
   input logic              tick_flag,
   input logic              tick_set,
   input logic              tick_ie,
   input logic              alm_ie,
   input logic [CNT_W-1:0]  sh_cnt,
   input logic [CNT_W-1:0]  cnt,
   input logic              core_tick,
   input logic              core_ld_cnt
);

   // R4: a count write outside configuration mode leaves the stored value alone
   a_r4_locked_count: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (bus_we && bus_addr == 3'd4 && !cfg_mode) |=> $stable(sh_cnt));

   // R6: the synchronised bit is never set while a transfer is in progress
   a_r6_sync_waits_done: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      !done |-> !synced);

   // R7: a tick event arriving on the bus side leaves the tick flag set
   a_r7_tick_sets_flag: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      tick_set |=> tick_flag);

   // R9: writing one keeps the flag
   a_r9_one_keeps_flag: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (bus_we && bus_addr == 3'd0 && bus_wdata[0] && tick_flag) |=> tick_flag);

   // R9: writing zero clears the flag when no new event arrives
   a_r9_zero_clears_flag: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (bus_we && bus_addr == 3'd0 && !bus_wdata[0] && !tick_set) |=> !tick_flag);

   // R10: with both enables clear the interrupt stays low
   a_r10_irq_masked: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (!tick_ie && !alm_ie) |-> !irq);

   // R2: an unloaded tick adds exactly one
   a_r2_count_step: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
      (core_tick && !core_ld_cnt) |=> (cnt == $past(cnt) + CNT_W'(1)));

endmodule

bind sec_counter sec_counter_chk #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_chk (
   .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
   .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .irq(irq),
   .cfg_mode(cfg_mode), .done(done), .synced(synced),
   .tick_flag(tick_flag), .tick_set(tick_set), .tick_ie(tick_ie), .alm_ie(alm_ie),
   .sh_cnt(sh_cnt), .cnt(cnt), .core_tick(core_tick), .core_ld_cnt(core_ld_cnt)
);

// File: tb/sec_counter_bench.sv
module sec_counter_bench;

   localparam int BUS_PERIOD  = 10;
   localparam int SLOW_PERIOD = 70;

   logic        bus_clk = 1'b0;
   logic        slow_clk = 1'b0;
   logic        bus_rst_n = 1'b0;
   logic        slow_rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   logic [15:0] ien = '0;

   always #(BUS_PERIOD/2)  bus_clk  = ~bus_clk;
   always #(SLOW_PERIOD/2) slow_clk = ~slow_clk;

   sec_counter #(.RESET_RELOAD(7)) u_sec_counter (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge bus_clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge bus_clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
      @(negedge bus_clk);
      bus_addr = a; bus_re = 1'b1;
      #2 d = bus_rdata;
      @(posedge bus_clk); #1;
      bus_re = 1'b0;
   endtask

   task automatic read_count(output logic [31:0] v);
      logic [15:0] lo, hi;
      bus_read(3'd4, lo);
      bus_read(3'd3, hi);
      v = {hi, lo};
   endtask

   task automatic wait_change(output logic [31:0] v);
      logic [31:0] first, cur;
      read_count(first);
      cur = first;
      for (int i = 0; i < 2000 && cur == first; i++) read_count(cur);
      v = cur;
   endtask

   task automatic cfg_load(input logic [19:0] rld, input logic [31:0] c, input logic [31:0] al);
      logic [15:0] st;
      bus_write(3'd0, ien | 16'h0007);
      bus_write(3'd1, {12'h0, rld[19:16]});
      bus_write(3'd2, rld[15:0]);
      bus_write(3'd3, c[31:16]);
      bus_write(3'd4, c[15:0]);
      bus_write(3'd5, al[31:16]);
      bus_write(3'd6, al[15:0]);
      bus_write(3'd0, ien | 16'h0003);
      bus_read(3'd0, st);
      for (int i = 0; i < 500 && !st[3]; i++) bus_read(3'd0, st);
      check("R5", "done after transfer", {31'd0, st[3]}, 32'd1);
   endtask

   task automatic t_reset;
      logic [15:0] st;
      bus_read(3'd0, st);
      check("R11", "control after reset", {16'd0, st}, 32'h0008);
      check("R11", "irq after reset", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_locked;
      logic [15:0] d;
      logic [31:0] v;
      bus_write(3'd3, 16'hABCD);
      bus_write(3'd5, 16'h1234);
      bus_write(3'd2, 16'h0001);
      bus_read(3'd5, d);
      check("R4", "alarm high unchanged", {16'd0, d}, 32'h0000FFFF);
      bus_read(3'd2, d);
      check("R4", "reload low unchanged", {16'd0, d}, 32'h00000007);
      read_count(v);
      check("R4", "count high unchanged", {16'd0, v[31:16]}, 32'd0);
   endtask

   task automatic t_config;
      logic [15:0] st;
      logic [31:0] v;
      ien = '0;
      bus_write(3'd0, 16'h0007);
      bus_write(3'd2, 16'd3);
      bus_write(3'd1, 16'd0);
      bus_write(3'd3, 16'h0001);
      bus_write(3'd4, 16'hFFFE);
      bus_write(3'd0, 16'h0003);
      bus_read(3'd0, st);
      check("R5", "done low during transfer", {31'd0, st[3]}, 32'd0);
      check("R6", "synced low during transfer", {31'd0, st[4]}, 32'd0);
      for (int i = 0; i < 500 && !st[3]; i++) bus_read(3'd0, st);
      check("R6", "synced after transfer", {31'd0, st[4]}, 32'd1);
      read_count(v);
      check("R5", "loaded count", v, 32'h0001FFFE);
      bus_write(3'd0, 16'h0002);
      bus_read(3'd0, st);
      check("R9", "tick flag cleared by zero", {31'd0, st[0]}, 32'd0);
      wait_change(v);
      check("R2", "count step", v, 32'h0001FFFF);
      bus_read(3'd0, st);
      check("R7", "tick flag on increment", {31'd0, st[0]}, 32'd1);
      wait_change(v);
      check("R2", "carry into high half", v, 32'h00020000);
   endtask

   task automatic t_period(input int rld);
      logic [31:0] v;
      time t0, t1;
      cfg_load(20'(rld), 32'd100, 32'hFFFF_0000);
      wait_change(v);
      t0 = $time;
      wait_change(v);
      t1 = $time;
      checks++;
      if ((t1 - t0) + 20 < time'((rld + 1) * SLOW_PERIOD) || (t1 - t0) > time'((rld + 1) * SLOW_PERIOD + 20)) begin
         fails++;
         $display("FAIL R1 tick interval: actual %0t expected %0d", t1 - t0, (rld + 1) * SLOW_PERIOD);
      end
   endtask

   task automatic t_wrap;
      logic [31:0] v;
      cfg_load(20'd3, 32'hFFFF_FFFE, 32'h0000_1000);
      wait_change(v);
      check("R3", "step to all ones", v, 32'hFFFF_FFFF);
      wait_change(v);
      check("R3", "wrap to zero", v, 32'h0000_0000);
   endtask

   task automatic t_alarm;
      logic [15:0] st;
      logic [31:0] v;
      ien = 16'h0040;
      cfg_load(20'd3, 32'd10, 32'd12);
      bus_write(3'd0, ien | 16'h0001);
      wait_change(v);
      bus_read(3'd0, st);
      check("R8", "no alarm one step early", {31'd0, st[1]}, 32'd0);
      check("R10", "irq low without flag", {31'd0, irq}, 32'd0);
      wait_change(v);
      check("R8", "count at compare", v, 32'd12);
      bus_read(3'd0, st);
      check("R8", "alarm flag on match", {31'd0, st[1]}, 32'd1);
      check("R10", "irq from alarm", {31'd0, irq}, 32'd1);
      bus_write(3'd0, ien | 16'h0002);
      bus_read(3'd0, st);
      check("R9", "alarm flag kept by one", {31'd0, st[1]}, 32'd1);
      ien = '0;
      bus_write(3'd0, 16'h0003);
      check("R10", "irq masked", {31'd0, irq}, 32'd0);
      bus_write(3'd0, 16'h0001);
      bus_read(3'd0, st);
      check("R9", "alarm flag cleared by zero", {31'd0, st[1]}, 32'd0);
      ien = 16'h0020;
      bus_write(3'd0, 16'h0020);
      wait_change(v);
      check("R10", "irq from tick", {31'd0, irq}, 32'd1);
   endtask

   initial begin
      #(BUS_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(BUS_PERIOD * 3 + 3);
      bus_rst_n = 1'b1;
      slow_rst_n = 1'b1;
      t_reset();
      t_locked();
      t_config();
      t_period(3);
      t_period(5);
      t_wrap();
      t_alarm();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule